// File: doc/BRIEF.md
# UART Channel Mode Router with Byte FIFOs

This block sits between the serial side of a UART and the processor's data register. It owns two byte queues, one for receive and one for transmit, and steers every byte according to a two-bit channel mode. In normal operation, line bytes are queued for the processor and processor writes are queued for the line. The block can also echo line bytes back out, loop processor writes back to the processor, or return line bytes to the line without processor involvement.

The block holds a small control register. This register provides per-direction on and off bits, and a flush bit for each queue that clears itself after use. The block reports a dropped byte when the receive queue is full. It also signals a receive timeout once the line has been quiet for four character times after the last byte that was queued. Both queue fill levels are exported to the interrupt logic. A received break is stored as a zero byte.

Top module: `uart_chan_router`

## Requirements
- R1: After synchronous reset, ctrl_q reads 0x128 (both directions off, bit 8 set), both counts are 0, tx_valid is 0 and dat_rdata is 0.
- R2: A direction is on only when its on bit is 1 and its off bit is 0 (receive: on bit 2, off bit 3; transmit: on bit 4, off bit 5). While receive is off, bytes bound for the receive queue are discarded and reads return 0 without consuming anything. While transmit is off, bytes bound for the transmit queue are discarded and tx_valid stays 0.
- R3: mode_sel encodes 0 = normal, 1 = echo, 2 = local loop, 3 = remote loop. A line byte (rx_valid) enters the receive queue only in modes 0 and 1.
- R4: A line byte enters the transmit queue only in modes 1 and 3.
- R5: A processor data write (dat_we) enters the transmit queue in mode 0 and the receive queue in mode 2. In modes 1 and 3 it is ignored.
- R6: Writing ctrl with bit 0 set empties the receive queue, and with bit 1 set empties the transmit queue, each independently. Both bits always read back as 0.
- R7: A byte bound for a full receive queue (DEPTH entries) is discarded. ev_rx_overrun pulses for one cycle, and the stored contents are unchanged.
- R8: A read (dat_re) returns the oldest receive byte on dat_rdata in the cycle after the request, in arrival order. A read of an empty queue returns 0.
- R9: Each byte accepted into the receive queue restarts a timer. ev_rx_timeout pulses once, 4*char_time clock edges after the accepting edge, unless another byte is accepted first. Flushing the receive queue cancels a pending timeout.
- R10: A break (rx_break) in modes 0 and 1 is stored in the receive queue as 0x00 and is never sent to the transmit queue.
- R11: The transmit queue presents its oldest byte on tx_byte with tx_valid. The byte is removed on a cycle where tx_valid and tx_ready are both 1, and bytes leave in the order they were queued.
- R12: A byte bound for a full transmit queue is discarded, and the queue keeps its first DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Channel mode |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_q | output | 9 | Control register contents |
| char_time | input | CT_W | Clock cycles per character |
| dat_we | input | 1 | Processor data write strobe |
| dat_wdata | input | DW | Processor write byte |
| dat_re | input | 1 | Processor data read strobe |
| dat_rdata | output | DW | Read byte, valid the cycle after dat_re |
| rx_valid | input | 1 | Line byte strobe |
| rx_byte | input | DW | Line byte |
| rx_break | input | 1 | Break received on the line |
| tx_valid | output | 1 | Transmit byte available |
| tx_byte | output | DW | Transmit byte |
| tx_ready | input | 1 | Transmitter accepts tx_byte |
| rx_count | output | $clog2(DEPTH+1) | Receive queue fill |
| tx_count | output | $clog2(DEPTH+1) | Transmit queue fill |
| ev_rx_overrun | output | 1 | One-cycle pulse on a dropped receive byte |
| ev_rx_timeout | output | 1 | One-cycle pulse on receive idle timeout |

## Verification
A corrupted queue pointer or count becomes visible at the next handshake or read: bytes come out reordered, duplicated or missing, or a count port disagrees with the number of bytes pushed. A wrong mode decode puts bytes into the wrong queue, and this shows on the count ports in the cycle after the strobe. An error in the idle timer moves the timeout pulse by one or more edges away from the exact expected cycle, or produces a second pulse. For this reason the pulse position is measured to the exact cycle.

// File: rtl/uart_cm_pkg.sv
package uart_cm_pkg;

    typedef enum logic [1:0] {
        CM_NORMAL      = 2'd0,
        CM_ECHO        = 2'd1,
        CM_LOCAL_LOOP  = 2'd2,
        CM_REMOTE_LOOP = 2'd3
    } chan_mode_e;

    localparam int CTRL_W      = 9;
    localparam int CB_RX_FLUSH = 0;
    localparam int CB_TX_FLUSH = 1;
    localparam int CB_RX_ON    = 2;
    localparam int CB_RX_OFF   = 3;
    localparam int CB_TX_ON    = 4;
    localparam int CB_TX_OFF   = 5;

    localparam logic [CTRL_W-1:0] CTRL_INIT  = 9'h128;
    localparam logic [CTRL_W-1:0] FLUSH_MASK = 9'h003;

    typedef struct packed {
        logic rx_on;
        logic tx_on;
        logic rx_flush;
        logic tx_flush;
    } ctrl_view_t;

    function automatic logic line_feeds_rx(chan_mode_e m);
        return (m == CM_NORMAL) || (m == CM_ECHO);
    endfunction

    function automatic logic line_feeds_tx(chan_mode_e m);
        return (m == CM_ECHO) || (m == CM_REMOTE_LOOP);
    endfunction

    function automatic logic cpu_feeds_tx(chan_mode_e m);
        return m == CM_NORMAL;
    endfunction

    function automatic logic cpu_feeds_rx(chan_mode_e m);
        return m == CM_LOCAL_LOOP;
    endfunction

endpackage

// File: rtl/cm_ctrl_reg.sv
module cm_ctrl_reg
    import uart_cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q,
    output ctrl_view_t        view
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= CTRL_INIT;
        else if (we)
            q <= wdata & ~FLUSH_MASK;
    end

    always_comb begin
        view.rx_on    = q[CB_RX_ON] & ~q[CB_RX_OFF];
        view.tx_on    = q[CB_TX_ON] & ~q[CB_TX_OFF];
        view.rx_flush = we & wdata[CB_RX_FLUSH];
        view.tx_flush = we & wdata[CB_TX_FLUSH];
    end

    // R6: flush bits never stick in the register
    a_r6_self_clear: assert property (@(posedge clk) disable iff (rst)
        we |=> (q[CB_TX_FLUSH:CB_RX_FLUSH] == 2'b00));

endmodule

// File: rtl/cm_fifo.sv
module cm_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // R7 / R12: a push into a full queue changes neither fill nor head
    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)) && $stable(dout));

    // R6: flush leaves the queue empty
    a_r6_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R8: popping an empty queue does not underflow
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/cm_rx_timeout.sv
module cm_rx_timeout #(
    parameter int CT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            kick,
    input  logic            cancel,
    input  logic [CT_W-1:0] char_time,
    output logic            fire
);

    localparam int LW = CT_W + 2;

    logic [LW-1:0] limit, elapsed;
    logic          armed;

    assign limit = {char_time, 2'b00};

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            armed   <= 1'b0;
            elapsed <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (kick) begin
                armed   <= 1'b1;
                elapsed <= '0;
            end else if (armed) begin
                if (elapsed == limit - LW'(1)) begin
                    armed <= 1'b0;
                    fire  <= 1'b1;
                end else begin
                    elapsed <= elapsed + LW'(1);
                end
            end
        end
    end

    // R9: the event is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R9: a new byte always restarts the wait
    a_r9_kick_restarts: assert property (@(posedge clk) disable iff (rst)
        kick |=> !fire);

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_cm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int CT_W  = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic [CT_W-1:0]   char_time,
    input  logic              dat_we,
    input  logic [DW-1:0]     dat_wdata,
    input  logic              dat_re,
    output logic [DW-1:0]     dat_rdata,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_byte,
    input  logic              rx_break,
    output logic              tx_valid,
    output logic [DW-1:0]     tx_byte,
    input  logic              tx_ready,
    output logic [CW-1:0]     rx_count,
    output logic [CW-1:0]     tx_count,
    output logic              ev_rx_overrun,
    output logic              ev_rx_timeout
);

    chan_mode_e  mode;
    ctrl_view_t  cv;
    logic          rx_req, tx_req, rx_accept;
    logic [DW-1:0] rx_din, tx_din, rx_head;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          rx_pop;

    assign mode = chan_mode_e'(mode_sel);

    cm_ctrl_reg u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .we   (ctrl_we),
        .wdata(ctrl_wdata),
        .q    (ctrl_q),
        .view (cv)
    );

    // Steering: the mode functions are mutually exclusive per queue
    always_comb begin
        rx_req = cv.rx_on & (((rx_valid | rx_break) & line_feeds_rx(mode)) |
                             (dat_we & cpu_feeds_rx(mode)));
        rx_din = line_feeds_rx(mode) ? (rx_break ? '0 : rx_byte) : dat_wdata;
        tx_req = cv.tx_on & ((rx_valid & ~rx_break & line_feeds_tx(mode)) |
                             (dat_we & cpu_feeds_tx(mode)));
        tx_din = line_feeds_tx(mode) ? rx_byte : dat_wdata;
    end

    assign rx_accept = rx_req & ~rx_full & ~cv.rx_flush;
    assign rx_pop    = dat_re & cv.rx_on & ~cv.rx_flush;
    assign tx_valid  = cv.tx_on & ~tx_empty;

    cm_fifo #(.DEPTH(DEPTH), .W(DW)) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .flush(cv.rx_flush),
        .push (rx_req),
        .din  (rx_din),
        .pop  (rx_pop),
        .dout (rx_head),
        .count(rx_count),
        .full (rx_full),
        .empty(rx_empty)
    );

    cm_fifo #(.DEPTH(DEPTH), .W(DW)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .flush(cv.tx_flush),
        .push (tx_req),
        .din  (tx_din),
        .pop  (tx_valid & tx_ready),
        .dout (tx_byte),
        .count(tx_count),
        .full (tx_full),
        .empty(tx_empty)
    );

    cm_rx_timeout #(.CT_W(CT_W)) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .kick     (rx_accept),
        .cancel   (cv.rx_flush),
        .char_time(char_time),
        .fire     (ev_rx_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_rdata     <= '0;
            ev_rx_overrun <= 1'b0;
        end else begin
            ev_rx_overrun <= rx_req & rx_full & ~cv.rx_flush;
            if (dat_re)
                dat_rdata <= (cv.rx_on && !rx_empty) ? rx_head : '0;
        end
    end

    // R7: a drop is only reported when the queue was full
    a_r7_overrun_when_full: assert property (@(posedge clk) disable iff (rst)
        ev_rx_overrun |-> ($past(rx_count) == CW'(DEPTH)));

    // R2: with receive switched off and no control write, the fill is frozen
    a_r2_rx_frozen: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[CB_RX_OFF] && !ctrl_we) |=> (rx_count == $past(rx_count)));

    // R12: transmit fill never exceeds the depth
    a_r12_tx_bound: assert property (@(posedge clk) disable iff (rst)
        tx_count <= CW'(DEPTH));

endmodule

// File: tb/sim_uart_chan_router.sv
module sim_uart_chan_router;
    localparam int DEPTH = 64;
    localparam int DW    = 8;
    localparam int CT_W  = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]      mode_sel = 2'd0;
    logic            ctrl_we = 1'b0;
    logic [8:0]      ctrl_wdata = '0;
    logic [8:0]      ctrl_q;
    logic [CT_W-1:0] char_time = 16'd2;
    logic            dat_we = 1'b0;
    logic [DW-1:0]   dat_wdata = '0;
    logic            dat_re = 1'b0;
    logic [DW-1:0]   dat_rdata;
    logic            rx_valid = 1'b0;
    logic [DW-1:0]   rx_byte = '0;
    logic            rx_break = 1'b0;
    logic            tx_valid;
    logic [DW-1:0]   tx_byte;
    logic            tx_ready = 1'b0;
    logic [CW-1:0]   rx_count, tx_count;
    logic            ev_rx_overrun, ev_rx_timeout;

    uart_chan_router #(.DEPTH(DEPTH), .DW(DW), .CT_W(CT_W)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .char_time(char_time),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_re(dat_re),
        .dat_rdata(dat_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_break(rx_break), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .rx_count(rx_count), .tx_count(tx_count),
        .ev_rx_overrun(ev_rx_overrun), .ev_rx_timeout(ev_rx_timeout)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rx_model[$];
    logic [7:0] tx_model[$];
    logic [7:0] rd_exp[$];
    logic [8:0] ctrl_m = 9'h128;
    bit rd_pend = 1'b0;

    function automatic bit rx_on_m();
        return ctrl_m[2] && !ctrl_m[3];
    endfunction
    function automatic bit tx_on_m();
        return ctrl_m[4] && !ctrl_m[5];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: compares read data and transmitted bytes against the scoreboard
    initial forever begin
        @(negedge clk); #1;
        if (rd_pend) begin
            rd_pend = 1'b0;
            if (rd_exp.size() == 0) check("R8", 1, 0, "unexpected read");
            else check("R8", dat_rdata, rd_exp.pop_front(), "read data");
        end
        if (dat_re) rd_pend = 1'b1;
        if (!rst && tx_valid && tx_ready) begin
            if (tx_model.size() == 0) check("R11", 1, 0, "unexpected tx byte");
            else check("R11", tx_byte, tx_model.pop_front(), "tx byte order");
        end
    end

    task automatic wr_ctrl(logic [8:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
        if (v[0]) rx_model.delete();
        if (v[1]) tx_model.delete();
        ctrl_m = v & 9'h1FC;
    endtask

    task automatic line_in(logic [7:0] b, bit brk);
        bit exp_ovr = 1'b0;
        bit m_rx = (mode_sel == 2'd0 || mode_sel == 2'd1) && rx_on_m();
        bit m_tx = !brk && (mode_sel == 2'd1 || mode_sel == 2'd3) && tx_on_m();
        if (m_rx) begin
            if (rx_model.size() < DEPTH) rx_model.push_back(brk ? 8'h00 : b);
            else exp_ovr = 1'b1;
        end
        if (m_tx && tx_model.size() < DEPTH) tx_model.push_back(b);
        @(negedge clk); rx_valid = !brk; rx_break = brk; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0; #1;
        check("R7", ev_rx_overrun, exp_ovr, "overrun event");
    endtask

    task automatic cpu_wr(logic [7:0] b);
        if (mode_sel == 2'd0 && tx_on_m() && tx_model.size() < DEPTH) tx_model.push_back(b);
        if (mode_sel == 2'd2 && rx_on_m() && rx_model.size() < DEPTH) rx_model.push_back(b);
        @(negedge clk); dat_we = 1'b1; dat_wdata = b;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic cpu_rd();
        if (rx_on_m() && rx_model.size() > 0) rd_exp.push_back(rx_model.pop_front());
        else rd_exp.push_back(8'h00);
        @(negedge clk); dat_re = 1'b1;
        @(negedge clk); dat_re = 1'b0;
    endtask

    task automatic counts(string req, string what);
        @(negedge clk); #1;
        check(req, rx_count, rx_model.size(), {what, " rx_count"});
        check(req, tx_count, tx_model.size(), {what, " tx_count"});
    endtask

    task automatic drain();
        @(negedge clk); tx_ready = 1'b1;
        for (int i = 0; i < 300 && tx_model.size() != 0; i++) begin
            @(negedge clk); #2;
        end
        @(negedge clk); tx_ready = 1'b0;
        #1 check("R11", tx_count, 0, "drained tx_count");
    endtask

    task automatic tmo_probe(int again_at, int flush_at, int expect_at, string what);
        int hits = 0;
        int first = 0;
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h5A;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            rx_valid   = (k == again_at);
            ctrl_we    = (k == flush_at);
            ctrl_wdata = 9'h015;
            #1;
            if (ev_rx_timeout) begin
                hits++;
                if (first == 0) first = k;
            end
        end
        ctrl_we = 1'b0;
        check("R9", hits, (expect_at == 0) ? 0 : 1, {what, " pulse count"});
        if (expect_at != 0) check("R9", first, expect_at, {what, " pulse cycle"});
        rx_model.delete();
        wr_ctrl(9'h015);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1", ctrl_q, 9'h128, "reset ctrl");
        check("R1", rx_count, 0, "reset rx_count");
        check("R1", tx_count, 0, "reset tx_count");
        check("R1", tx_valid, 0, "reset tx_valid");
        check("R1", dat_rdata, 0, "reset rdata");

        // R2: everything is off after reset
        line_in(8'h11, 1'b0);
        cpu_wr(8'h22);
        cpu_rd();
        counts("R2", "while off");

        // R3 R5 normal mode
        wr_ctrl(9'h014);
        line_in(8'hA1, 1'b0); line_in(8'hA2, 1'b0); line_in(8'hA3, 1'b0);
        cpu_wr(8'hB1); cpu_wr(8'hB2);
        counts("R3", "normal");
        cpu_rd(); cpu_rd(); cpu_rd(); cpu_rd();
        counts("R8", "empty read");
        // R2: transmit off holds the queue
        wr_ctrl(9'h024);
        @(negedge clk); tx_ready = 1'b1; #1;
        check("R2", tx_valid, 0, "tx off valid");
        @(negedge clk); tx_ready = 1'b0;
        wr_ctrl(9'h014);
        drain();

        // R4 echo mode
        mode_sel = 2'd1;
        line_in(8'hC1, 1'b0); line_in(8'hC2, 1'b0);
        cpu_wr(8'hC3);
        counts("R4", "echo");
        cpu_rd(); cpu_rd();
        drain();

        // R5 local loop
        mode_sel = 2'd2;
        cpu_wr(8'hD1); cpu_wr(8'hD2); cpu_wr(8'hD3);
        line_in(8'hD4, 1'b0);
        counts("R5", "local loop");
        cpu_rd(); cpu_rd(); cpu_rd();

        // R4 remote loop
        mode_sel = 2'd3;
        line_in(8'hE1, 1'b0); line_in(8'hE2, 1'b0);
        cpu_wr(8'hE3);
        counts("R4", "remote loop");
        drain();

        // R10 break
        mode_sel = 2'd1;
        line_in(8'hAA, 1'b1);
        line_in(8'h77, 1'b0);
        counts("R10", "break");
        cpu_rd(); cpu_rd();
        drain();
        mode_sel = 2'd0;

        // R2 off bit overrides on bit
        wr_ctrl(9'h01C);
        line_in(8'h31, 1'b0);
        cpu_wr(8'h32);
        counts("R2", "rx off override");
        cpu_rd();
        wr_ctrl(9'h014);
        drain();

        // R6 independent flushes
        line_in(8'h41, 1'b0); line_in(8'h42, 1'b0);
        cpu_wr(8'h43); cpu_wr(8'h44);
        wr_ctrl(9'h015);
        counts("R6", "rx flush");
        check("R6", ctrl_q, 9'h014, "flush bits clear");
        line_in(8'h45, 1'b0);
        wr_ctrl(9'h016);
        counts("R6", "tx flush");
        cpu_rd();

        // R7 overrun
        for (int i = 0; i < DEPTH; i++) line_in(8'(i + 8'h80), 1'b0);
        line_in(8'hFF, 1'b0);
        counts("R7", "full rx");
        for (int i = 0; i < DEPTH; i++) cpu_rd();
        counts("R7", "rx emptied");

        // R12 transmit full
        for (int i = 0; i <= DEPTH; i++) cpu_wr(8'(i + 8'h10));
        counts("R12", "full tx");
        drain();

        // R9 timeout
        tmo_probe(0, 0, 9, "single byte");
        tmo_probe(5, 0, 14, "restart");
        tmo_probe(0, 3, 0, "flush cancel");

        repeat (4) @(negedge clk);
        report();
        $finish;
    end
endmodule